// File: doc/BRIEF.md
# Burst Target Address Sequencer

This block sits behind a bus target and produces the address for each data phase of a burst. At the address phase it takes in the starting address, a two-bit burst-ordering code, an I/O-space flag, the byte enables and the current cache-line size. Each later pulse of the data-phase-done strobe moves the address to the next location. The step follows the chosen ordering.

Two orderings are supported. Linear ordering adds four bytes per data phase. Cache-line wrap starts at a mid-line offset and runs to the end of the line. It then goes back to the start of the line until the whole line has been moved. A burst that keeps going resumes at the same offset in the next line. Reserved ordering codes, or a wrap request that cannot be honoured, raise a disconnect request. The target logic uses this request to end the burst after its first data phase. For I/O-space accesses the ordering code is not used. Instead the low address bits are checked against the byte enables, and a mismatched pattern is flagged.

Top module: `burst_addr_seq`

## Requirements
- R1: After a synchronous reset, `cur_addr_o` is 0, `disconnect_o` is 0 and `be_illegal_o` is 0.
- R2: One cycle after `addr_phase_i`, `cur_addr_o` holds the start address. For memory space (`io_space_i`=0), bits [1:0] are cleared. For I/O space the address is kept whole.
- R3: With ordering code 2'b00 in memory space, each `phase_done_i` pulse adds 4 to `cur_addr_o` one cycle later, and `disconnect_o` stays 0.
- R4: With ordering code 2'b10, a mid-line start and `line_words_i` ≥ 2 (a power of two, line = 4×`line_words_i` bytes), the address steps by 4 and wraps from the line end to the line start. Once the whole line has been covered, it moves to the starting offset in the next line. For a 16-byte line starting at 0x208 the sequence is 0x208, 0x20C, 0x200, 0x204, 0x218.
- R5: Wrap ordering from a line-aligned start produces the same sequence as linear ordering, with no disconnect.
- R6: Ordering codes 2'b01 and 2'b11 in memory space set `disconnect_o` from the cycle after the address phase until the next address phase. The address still advances by 4 per data phase.
- R7: Ordering code 2'b10 with `line_words_i` of 0 or 1, or in a build with `WRAP_SUPPORTED`=0, sets `disconnect_o` and steps linearly.
- R8: In I/O space the ordering code has no effect. `disconnect_o` stays 0 and the address advances by 4 with its low bits kept.
- R9: In I/O space, with active-high `byte_en_i[3:0]` and low address bits n, the enable for lane n must be 1 and every lane below n must be 0. Lanes above n are free. A violation sets `be_illegal_o` one cycle after the address phase. `be_illegal_o` is always 0 for memory space.
- R10: With neither strobe high, `cur_addr_o` holds its value. When both strobes are high in the same cycle, the address-phase load takes priority.
- R11: The wrap length follows `line_words_i` as captured at the address phase. With 8 words, a start at 0x414 gives 0x414, 0x418, 0x41C, 0x400 … 0x410, 0x434.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_phase_i | input | 1 | Address-phase strobe; captures the burst set-up |
| start_addr_i | input | AW | Starting byte address |
| order_code_i | input | 2 | Burst ordering code (00 linear, 10 wrap, 01/11 reserved) |
| io_space_i | input | 1 | Access is to I/O space |
| byte_en_i | input | 4 | Active-high byte enables of the first data phase |
| line_words_i | input | LW | Cache-line size in 32-bit words |
| phase_done_i | input | 1 | A data phase has completed |
| cur_addr_o | output | AW | Address of the current data phase |
| disconnect_o | output | 1 | Terminate after the first data phase |
| be_illegal_o | output | 1 | I/O byte enables disagree with the low address bits |

## Verification
Every output comes from a register, so each result appears exactly one clock edge after the strobe that causes it. This holds for the address load, every step, the disconnect request and the byte-enable flag. The bench changes inputs on the falling edge and holds a strobe for one full cycle. It then reads the outputs on the next falling edge, which falls between the edge that updated them and the following one. Wrap sequences are checked step by step against addresses worked out by hand from the line size and start offset. This includes the jump into the next line.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic [1:0] {
    ORD_LINEAR = 2'b00,
    ORD_RSVD_A = 2'b01,
    ORD_WRAP   = 2'b10,
    ORD_RSVD_B = 2'b11
  } order_code_e;

  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned LANES      = 4;
endpackage

// File: rtl/bseq_mode_decode.sv
module bseq_mode_decode
  import bseq_pkg::*;
#(
  parameter int unsigned AW             = 32,
  parameter int unsigned LW             = 8,
  parameter bit          WRAP_SUPPORTED = 1'b1
) (
  input  logic [1:0]    order_code,
  input  logic          io_space,
  input  logic [LW-1:0] line_words,
  output logic          step_wrap,
  output logic          stop_first,
  output logic [AW-1:0] line_mask
);
  logic          wrap_ok;
  logic [AW-1:0] words_ext;

  assign words_ext = AW'(line_words);
  assign wrap_ok   = WRAP_SUPPORTED && (line_words >= LW'(2));

  always_comb begin
    step_wrap  = 1'b0;
    stop_first = 1'b0;
    line_mask  = '0;
    if (!io_space) begin
      case (order_code_e'(order_code))
        ORD_LINEAR: ;
        ORD_WRAP: begin
          if (wrap_ok) begin
            step_wrap = 1'b1;
            line_mask = (words_ext << 2) - AW'(1);
          end else begin
            stop_first = 1'b1;
          end
        end
        default: stop_first = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/bseq_next_addr.sv
module bseq_next_addr
  import bseq_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] start_off,
  input  logic [AW-1:0] line_mask,
  input  logic          step_wrap,
  output logic [AW-1:0] nxt_addr
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic [AW-1:0] in_off;
  logic [AW-1:0] nxt_off;
  logic [AW-1:0] line_base;

  assign in_off    = cur_addr & line_mask;
  assign nxt_off   = (in_off + STEP) & line_mask;
  assign line_base = cur_addr & ~line_mask;

  always_comb begin
    if (!step_wrap) begin
      nxt_addr = cur_addr + STEP;
    end else if (nxt_off == start_off) begin
      nxt_addr = (line_base + line_mask + AW'(1)) | start_off;
    end else begin
      nxt_addr = line_base | nxt_off;
    end
  end
endmodule

// File: rtl/bseq_be_check.sv
module bseq_be_check
  import bseq_pkg::*;
(
  input  logic [1:0]       low_bits,
  input  logic [LANES-1:0] byte_en,
  output logic             illegal
);
  always_comb begin
    illegal = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if ((i < int'(low_bits)) && byte_en[i]) illegal = 1'b1;
      if ((i == int'(low_bits)) && !byte_en[i]) illegal = 1'b1;
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int unsigned AW             = 32,
  parameter int unsigned LW             = 8,
  parameter bit          WRAP_SUPPORTED = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_phase_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [1:0]    order_code_i,
  input  logic          io_space_i,
  input  logic [3:0]    byte_en_i,
  input  logic [LW-1:0] line_words_i,
  input  logic          phase_done_i,
  output logic [AW-1:0] cur_addr_o,
  output logic          disconnect_o,
  output logic          be_illegal_o
);
  logic          dec_wrap, dec_stop, be_bad;
  logic [AW-1:0] dec_mask, nxt_addr, load_addr;

  logic [AW-1:0] addr_q, start_off_q, mask_q;
  logic          wrap_q, stop_q, bad_q;

  bseq_mode_decode #(.AW(AW), .LW(LW), .WRAP_SUPPORTED(WRAP_SUPPORTED)) u_dec (
    .order_code (order_code_i),
    .io_space   (io_space_i),
    .line_words (line_words_i),
    .step_wrap  (dec_wrap),
    .stop_first (dec_stop),
    .line_mask  (dec_mask)
  );

  bseq_next_addr #(.AW(AW)) u_nxt (
    .cur_addr  (addr_q),
    .start_off (start_off_q),
    .line_mask (mask_q),
    .step_wrap (wrap_q),
    .nxt_addr  (nxt_addr)
  );

  bseq_be_check u_be (
    .low_bits (start_addr_i[1:0]),
    .byte_en  (byte_en_i),
    .illegal  (be_bad)
  );

  assign load_addr = io_space_i ? start_addr_i : {start_addr_i[AW-1:2], 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q      <= '0;
      start_off_q <= '0;
      mask_q      <= '0;
      wrap_q      <= 1'b0;
      stop_q      <= 1'b0;
      bad_q       <= 1'b0;
    end else if (addr_phase_i) begin
      addr_q      <= load_addr;
      start_off_q <= load_addr & dec_mask;
      mask_q      <= dec_mask;
      wrap_q      <= dec_wrap;
      stop_q      <= dec_stop;
      bad_q       <= io_space_i & be_bad;
    end else if (phase_done_i) begin
      addr_q      <= nxt_addr;
    end
  end

  assign cur_addr_o   = addr_q;
  assign disconnect_o = stop_q;
  assign be_illegal_o = bad_q;

  // R2
  load_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_phase_i && !io_space_i) |=> (cur_addr_o == {$past(start_addr_i[AW-1:2]), 2'b00}));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_done_i && !addr_phase_i && !wrap_q) |=> (cur_addr_o == $past(cur_addr_o) + AW'(4)));

  // R4
  wrap_line_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_done_i && !addr_phase_i && wrap_q) |=>
      (((cur_addr_o & ~mask_q) == ($past(cur_addr_o) & ~mask_q)) ||
       ((cur_addr_o & mask_q) == start_off_q)));

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!addr_phase_i && !phase_done_i) |=> $stable(cur_addr_o));

  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !addr_phase_i |=> $stable(disconnect_o));

  // R9
  io_be_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_phase_i && io_space_i && start_addr_i[1:0] == 2'b11 && byte_en_i != 4'b1000)
      |=> be_illegal_o);

  // R8
  io_nostop_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_phase_i && io_space_i) |=> !disconnect_o);
endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int CLK_P = 10;
  localparam int AW    = 32;
  localparam int LW    = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          addr_phase = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [1:0]    order_code = 2'b00;
  logic          io_space = 1'b0;
  logic [3:0]    byte_en = 4'b0000;
  logic [LW-1:0] line_words = '0;
  logic          phase_done = 1'b0;
  logic [AW-1:0] cur_addr;
  logic          disc, be_ill;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  burst_addr_seq #(.AW(AW), .LW(LW), .WRAP_SUPPORTED(1'b1)) uut (
    .clk(clk), .rst(rst), .addr_phase_i(addr_phase), .start_addr_i(start_addr),
    .order_code_i(order_code), .io_space_i(io_space), .byte_en_i(byte_en),
    .line_words_i(line_words), .phase_done_i(phase_done),
    .cur_addr_o(cur_addr), .disconnect_o(disc), .be_illegal_o(be_ill)
  );

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic start_burst(input logic [AW-1:0] a, input logic [1:0] code, input logic io,
                             input logic [3:0] be, input logic [LW-1:0] lw);
    @(negedge clk);
    addr_phase = 1'b1; start_addr = a; order_code = code; io_space = io;
    byte_en = be; line_words = lw;
    @(negedge clk);
    addr_phase = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    phase_done = 1'b1;
    @(negedge clk);
    phase_done = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 addr", cur_addr, 0);
    check("R1 disconnect", AW'(disc), 0);
    check("R1 be_illegal", AW'(be_ill), 0);
  endtask

  task automatic t_linear();
    start_burst(32'h1003, 2'b00, 1'b0, 4'b1111, 8'd4);
    check("R2 load clears low bits", cur_addr, 32'h1000);
    check("R3 no disconnect", AW'(disc), 0);
    step(); check("R3 step1", cur_addr, 32'h1004);
    step(); check("R3 step2", cur_addr, 32'h1008);
  endtask

  task automatic t_wrap16();
    logic [AW-1:0] exp [7] = '{32'h20C, 32'h200, 32'h204, 32'h218, 32'h21C, 32'h210, 32'h214};
    start_burst(32'h208, 2'b10, 1'b0, 4'b1111, 8'd4);
    check("R4 start", cur_addr, 32'h208);
    check("R4 no disconnect", AW'(disc), 0);
    for (int i = 0; i < 7; i++) begin
      step(); check("R4 wrap seq", cur_addr, exp[i]);
    end
  endtask

  task automatic t_wrap_aligned();
    start_burst(32'h300, 2'b10, 1'b0, 4'b1111, 8'd4);
    for (int i = 1; i <= 5; i++) begin
      step(); check("R5 aligned wrap", cur_addr, 32'h300 + AW'(4*i));
    end
    check("R5 no disconnect", AW'(disc), 0);
  endtask

  task automatic t_wrap32();
    logic [AW-1:0] exp [8] = '{32'h418, 32'h41C, 32'h400, 32'h404, 32'h408, 32'h40C, 32'h410, 32'h434};
    start_burst(32'h414, 2'b10, 1'b0, 4'b1111, 8'd8);
    line_words = 8'd2;
    for (int i = 0; i < 8; i++) begin
      step(); check("R11 8-word wrap", cur_addr, exp[i]);
    end
  endtask

  task automatic t_reserved();
    start_burst(32'h500, 2'b01, 1'b0, 4'b1111, 8'd4);
    check("R6 code01 disconnect", AW'(disc), 1);
    step(); check("R6 linear advance", cur_addr, 32'h504);
    check("R6 held", AW'(disc), 1);
    start_burst(32'h600, 2'b11, 1'b0, 4'b1111, 8'd4);
    check("R6 code11 disconnect", AW'(disc), 1);
    start_burst(32'h600, 2'b00, 1'b0, 4'b1111, 8'd4);
    check("R6 cleared", AW'(disc), 0);
  endtask

  task automatic t_nowrap();
    start_burst(32'h708, 2'b10, 1'b0, 4'b1111, 8'd1);
    check("R7 lw1 disconnect", AW'(disc), 1);
    step(); check("R7 lw1 linear", cur_addr, 32'h70C);
    step(); check("R7 lw1 linear2", cur_addr, 32'h710);
    start_burst(32'h808, 2'b10, 1'b0, 4'b1111, 8'd0);
    check("R7 lw0 disconnect", AW'(disc), 1);
  endtask

  task automatic t_io();
    start_burst(32'h8003, 2'b10, 1'b1, 4'b1000, 8'd4);
    check("R8 io load", cur_addr, 32'h8003);
    check("R8 io no disconnect", AW'(disc), 0);
    step(); check("R8 io step", cur_addr, 32'h8007);
    start_burst(32'h9001, 2'b01, 1'b1, 4'b0010, 8'd4);
    check("R8 io reserved ignored", AW'(disc), 0);
  endtask

  task automatic t_be();
    start_burst(32'hA003, 2'b00, 1'b1, 4'b1000, 8'd4); check("R9 11 ok", AW'(be_ill), 0);
    start_burst(32'hA003, 2'b00, 1'b1, 4'b1100, 8'd4); check("R9 11 bad", AW'(be_ill), 1);
    start_burst(32'hA000, 2'b00, 1'b1, 4'b0001, 8'd4); check("R9 00 ok", AW'(be_ill), 0);
    start_burst(32'hA000, 2'b00, 1'b1, 4'b1110, 8'd4); check("R9 00 bad", AW'(be_ill), 1);
    start_burst(32'hA001, 2'b00, 1'b1, 4'b0110, 8'd4); check("R9 01 ok", AW'(be_ill), 0);
    start_burst(32'hA001, 2'b00, 1'b1, 4'b0011, 8'd4); check("R9 01 bad", AW'(be_ill), 1);
    start_burst(32'hA002, 2'b00, 1'b1, 4'b1100, 8'd4); check("R9 10 ok", AW'(be_ill), 0);
    start_burst(32'hA002, 2'b00, 1'b1, 4'b1110, 8'd4); check("R9 10 bad", AW'(be_ill), 1);
    start_burst(32'hA000, 2'b00, 1'b0, 4'b0110, 8'd4); check("R9 memory never flagged", AW'(be_ill), 0);
  endtask

  task automatic t_priority();
    start_burst(32'hB000, 2'b00, 1'b0, 4'b1111, 8'd4);
    repeat (3) @(negedge clk);
    check("R10 idle hold", cur_addr, 32'hB000);
    @(negedge clk);
    addr_phase = 1'b1; phase_done = 1'b1; start_addr = 32'hC010; order_code = 2'b00;
    @(negedge clk);
    addr_phase = 1'b0; phase_done = 1'b0;
    check("R10 load wins", cur_addr, 32'hC010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_linear();
    t_wrap16();
    t_wrap_aligned();
    t_wrap32();
    t_reserved();
    t_nowrap();
    t_io();
    t_be();
    t_priority();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule